// File: doc/BRIEF.md
# Display RAM Address Sequencer

This block sits between a serial-bus slave front end and a display memory of 4 banks. Each bank holds 40 bytes, and each byte holds 8 vertically stacked pixel rows of one column. The front end decodes three kinds of command and hands them over as single-cycle valid pulses. A device-select command loads the cascade subaddress counter. A column-load command sets the X pointer, which is the column output number; columns 0 to 7 can be stored and read back but are never shown. An access command sets the bank and one of three traversal orders. After that, every data-byte strobe reads or writes one byte at the current pointer, and the pointer then moves on according to the chosen order.

Several of these devices can share one bus in a cascade. Each device keeps a copy of the 4-bit subaddress counter. The counter steps when a device's whole area has been traversed. A device touches its memory only while the counter equals its own hardware subaddress, which is fixed at 0 here. Memory traffic is allowed only when the mixed-mode input is high. In row-only operation, data strobes have no effect at all.

Top module: `dram_addr_seq`

## Requirements
- R1: After reset the pointer is column 0, bank 0, the subaddress counter is 0, the order is character, and neither `ram_we` nor `ram_re` is asserted.
- R2: `cmd_dev_vld` loads `sub_cnt` from `cmd_dev_sub`. `cmd_acc_vld` sets the bank, and the group start bank, from `cmd_acc_bank`, and sets the order from `cmd_acc_mode`, where 00 = character, 01 = half-graphic and 10 = full-graphic. `cmd_x_vld` sets both the column and the start column. Each load is visible on the cycle after the pulse.
- R3: A column load with a value above 39 is ignored, and the column is unchanged.
- R4: Full-graphic order: the column increments after each byte. After column 39 the column returns to the start column and the bank increments modulo 4. When the bank comes back to the start bank, `sub_cnt` increments.
- R5: Character order: the column increments within an 8-column cell (columns 8k to 8k+7). After the cell's last column, the column returns to the cell base and the bank increments. When the bank comes back to the start bank, the column moves to the next cell instead. After column 39 it returns to the start column and `sub_cnt` increments.
- R6: Half-graphic order: each column is visited in bank b and then in bank b+1. The column then advances and the bank returns to b. After column 39 the column returns to the start column and the bank pair advances by 2. When the pair base comes back to the start bank, `sub_cnt` increments.
- R7: `ram_we` is high exactly in a cycle with `byte_stb` high, `byte_rd` low, mixed mode, no command pulse and `sub_cnt` = 0. The pointer advances on the clock edge that ends that cycle.
- R8: `ram_re` follows the same rule with `byte_rd` high. Reads advance the pointer in the same way as writes.
- R9: `sub_cnt` is 4 bits wide and wraps from 15 to 0.
- R10: While `sub_cnt` is not 0, strobes still advance the pointer but assert neither enable.
- R11: With `mixed_mode` low, strobes assert no enable and leave the pointer and `sub_cnt` unchanged.
- R12: Order code 11 traverses exactly like full-graphic.
- R13: A strobe in the same cycle as any command pulse is dropped: it asserts no enable and causes no advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mixed_mode | input | 1 | 1 = memory traffic allowed, 0 = row-only |
| cmd_dev_vld | input | 1 | Device-select pulse |
| cmd_dev_sub | input | 4 | Subaddress to load |
| cmd_x_vld | input | 1 | Column-load pulse |
| cmd_x | input | 6 | Column to load |
| cmd_acc_vld | input | 1 | Access command pulse |
| cmd_acc_mode | input | 2 | Traversal order code |
| cmd_acc_bank | input | 2 | Start bank |
| byte_stb | input | 1 | Data-byte strobe |
| byte_rd | input | 1 | 1 = strobe is a read, 0 = write |
| ram_col | output | 6 | Current column address |
| ram_bank | output | 2 | Current bank address |
| ram_we | output | 1 | Memory write enable |
| ram_re | output | 1 | Memory read enable |
| sub_cnt | output | 4 | Cascade subaddress counter |

## Verification
The bench aims at the edges of each traversal. It starts near column 39, so that the end-of-row wrap comes back to an unaligned start column rather than to 0; a design that wrapped to 0 would be caught at once. It uses a non-zero start bank, so a design that compared against bank 0 would step the subaddress at the wrong moment. It loads the subaddress 15 so the counter must wrap to 0, at which point writes must resume. It also checks that strobes are silent in row-only mode, after a mismatch, and in a cycle with a command pulse, and that a column load above 39 is rejected. A design that let any of these through would move the pointer or pulse an enable where the model holds still.

// File: rtl/dram_pkg.sv
package dram_pkg;
   typedef enum logic [1:0] {
      ACC_CHAR = 2'b00,
      ACC_HALF = 2'b01,
      ACC_FULL = 2'b10,
      ACC_RSVD = 2'b11
   } acc_mode_e;
endpackage

// File: rtl/dram_ptr_step.sv
// Next-pointer logic: computes where the following byte goes.
module dram_ptr_step
   import dram_pkg::*;
#(
   parameter int NUM_COLS     = 40,
   parameter int NUM_BANKS    = 4,
   parameter int CELL_W       = 8,
   parameter bit RSVD_AS_FULL = 1'b1,
   localparam int COL_W  = $clog2(NUM_COLS),
   localparam int BANK_W = $clog2(NUM_BANKS),
   localparam int CELL_B = $clog2(CELL_W)
) (
   input  acc_mode_e          mode_i,
   input  logic [COL_W-1:0]   col_i,
   input  logic [COL_W-1:0]   col_start_i,
   input  logic [BANK_W-1:0]  bank_i,
   input  logic [BANK_W-1:0]  bank_start_i,
   input  logic               half_i,
   output logic [COL_W-1:0]   col_o,
   output logic [BANK_W-1:0]  bank_o,
   output logic               half_o,
   output logic               wrap_o
);
   localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
   localparam logic [COL_W-1:0]  CELL_MASK = COL_W'(CELL_W - 1);
   localparam logic [CELL_B-1:0] CELL_END  = CELL_B'(CELL_W - 1);

   acc_mode_e eff_mode;

   generate
      if (RSVD_AS_FULL) begin : g_rsvd_full
         assign eff_mode = (mode_i == ACC_RSVD) ? ACC_FULL : mode_i;
      end else begin : g_rsvd_char
         assign eff_mode = (mode_i == ACC_RSVD) ? ACC_CHAR : mode_i;
      end
   endgenerate

   logic              last_col;
   logic              cell_end;
   logic [BANK_W-1:0] bank_inc;
   logic [BANK_W-1:0] bank_dec;
   logic [BANK_W-1:0] bank_pair;

   assign last_col  = (col_i == LAST_COL);
   assign cell_end  = (col_i[CELL_B-1:0] == CELL_END);
   assign bank_inc  = bank_i + BANK_W'(1);
   assign bank_dec  = bank_i - BANK_W'(1);
   assign bank_pair = bank_i + BANK_W'(1);

   always_comb begin
      col_o  = col_i;
      bank_o = bank_i;
      half_o = half_i;
      wrap_o = 1'b0;
      unique case (eff_mode)
         ACC_FULL: begin
            if (last_col) begin
               col_o  = col_start_i;
               bank_o = bank_inc;
               wrap_o = (bank_inc == bank_start_i);
            end else begin
               col_o = col_i + COL_W'(1);
            end
         end
         ACC_CHAR: begin
            if (!cell_end) begin
               col_o = col_i + COL_W'(1);
            end else if (bank_inc != bank_start_i) begin
               col_o  = col_i & ~CELL_MASK;
               bank_o = bank_inc;
            end else begin
               bank_o = bank_inc;
               if (last_col) begin
                  col_o  = col_start_i;
                  wrap_o = 1'b1;
               end else begin
                  col_o = col_i + COL_W'(1);
               end
            end
         end
         ACC_HALF: begin
            if (!half_i) begin
               bank_o = bank_inc;
               half_o = 1'b1;
            end else begin
               half_o = 1'b0;
               if (last_col) begin
                  col_o  = col_start_i;
                  bank_o = bank_pair;
                  wrap_o = (bank_pair == bank_start_i);
               end else begin
                  col_o  = col_i + COL_W'(1);
                  bank_o = bank_dec;
               end
            end
         end
         default: begin
            col_o = col_i;
         end
      endcase
   end
endmodule

// File: rtl/dram_sub_gate.sv
// Cascade subaddress counter and local match.
module dram_sub_gate #(
   parameter int SUB_W  = 4,
   parameter int HW_SUB = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [SUB_W-1:0] load_val_i,
   input  logic             step_i,
   output logic [SUB_W-1:0] sub_o,
   output logic             match_o
);
   localparam logic [SUB_W-1:0] LOCAL_SUB = SUB_W'(HW_SUB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_o <= '0;
      end else if (load_i) begin
         sub_o <= load_val_i;
      end else if (step_i) begin
         sub_o <= sub_o + SUB_W'(1);
      end
   end

   assign match_o = (sub_o == LOCAL_SUB);
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
   import dram_pkg::*;
#(
   parameter int NUM_COLS     = 40,
   parameter int NUM_BANKS    = 4,
   parameter int CELL_W       = 8,
   parameter int SUB_W        = 4,
   parameter int HW_SUB       = 0,
   parameter bit RSVD_AS_FULL = 1'b1,
   localparam int COL_W  = $clog2(NUM_COLS),
   localparam int BANK_W = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mixed_mode,
   input  logic              cmd_dev_vld,
   input  logic [SUB_W-1:0]  cmd_dev_sub,
   input  logic              cmd_x_vld,
   input  logic [COL_W-1:0]  cmd_x,
   input  logic              cmd_acc_vld,
   input  logic [1:0]        cmd_acc_mode,
   input  logic [BANK_W-1:0] cmd_acc_bank,
   input  logic              byte_stb,
   input  logic              byte_rd,
   output logic [COL_W-1:0]  ram_col,
   output logic [BANK_W-1:0] ram_bank,
   output logic              ram_we,
   output logic              ram_re,
   output logic [SUB_W-1:0]  sub_cnt
);
   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (CELL_W < 2 || (CELL_W & (CELL_W - 1)) != 0) begin : g_bad_cell
         $error("CELL_W must be a power of two of at least 2");
      end
      if (NUM_COLS % CELL_W != 0) begin : g_bad_cols
         $error("NUM_COLS must be a multiple of CELL_W");
      end
      if (HW_SUB < 0 || HW_SUB >= (1 << SUB_W)) begin : g_bad_sub
         $error("HW_SUB must fit in SUB_W bits");
      end
   endgenerate

   localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

   logic [COL_W-1:0]  col_q, col_start_q, col_nxt;
   logic [BANK_W-1:0] bank_q, bank_start_q, bank_nxt;
   logic              half_q, half_nxt, wrap;
   acc_mode_e         mode_q;
   logic              any_cmd, advance, match;

   assign any_cmd = cmd_dev_vld | cmd_x_vld | cmd_acc_vld;
   assign advance = byte_stb & mixed_mode & ~any_cmd;

   dram_ptr_step #(
      .NUM_COLS    (NUM_COLS),
      .NUM_BANKS   (NUM_BANKS),
      .CELL_W      (CELL_W),
      .RSVD_AS_FULL(RSVD_AS_FULL)
   ) u_step (
      .mode_i      (mode_q),
      .col_i       (col_q),
      .col_start_i (col_start_q),
      .bank_i      (bank_q),
      .bank_start_i(bank_start_q),
      .half_i      (half_q),
      .col_o       (col_nxt),
      .bank_o      (bank_nxt),
      .half_o      (half_nxt),
      .wrap_o      (wrap)
   );

   dram_sub_gate #(
      .SUB_W (SUB_W),
      .HW_SUB(HW_SUB)
   ) u_sub (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (cmd_dev_vld),
      .load_val_i(cmd_dev_sub),
      .step_i    (advance & wrap),
      .sub_o     (sub_cnt),
      .match_o   (match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q        <= '0;
         col_start_q  <= '0;
         bank_q       <= '0;
         bank_start_q <= '0;
         half_q       <= 1'b0;
         mode_q       <= ACC_CHAR;
      end else if (any_cmd) begin
         if (cmd_x_vld && cmd_x <= LAST_COL) begin
            col_q       <= cmd_x;
            col_start_q <= cmd_x;
            half_q      <= 1'b0;
         end
         if (cmd_acc_vld) begin
            mode_q       <= acc_mode_e'(cmd_acc_mode);
            bank_q       <= cmd_acc_bank;
            bank_start_q <= cmd_acc_bank;
            half_q       <= 1'b0;
         end
      end else if (advance) begin
         col_q  <= col_nxt;
         bank_q <= bank_nxt;
         half_q <= half_nxt;
      end
   end

   assign ram_col  = col_q;
   assign ram_bank = bank_q;
   assign ram_we   = advance & match & ~byte_rd;
   assign ram_re   = advance & match & byte_rd;
endmodule

// File: rtl/dram_addr_seq_chk.sv
module dram_addr_seq_chk #(
   parameter int NUM_COLS  = 40,
   parameter int NUM_BANKS = 4,
   parameter int SUB_W     = 4,
   parameter int HW_SUB    = 0,
   localparam int COL_W  = $clog2(NUM_COLS),
   localparam int BANK_W = $clog2(NUM_BANKS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mixed_mode,
   input logic              cmd_dev_vld,
   input logic              cmd_x_vld,
   input logic              cmd_acc_vld,
   input logic              byte_stb,
   input logic              byte_rd,
   input logic [COL_W-1:0]  ram_col,
   input logic [BANK_W-1:0] ram_bank,
   input logic              ram_we,
   input logic              ram_re,
   input logic [SUB_W-1:0]  sub_cnt
);
   logic no_cmd;
   assign no_cmd = !cmd_dev_vld && !cmd_x_vld && !cmd_acc_vld;

   a_r7_we_needs_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (byte_stb && !byte_rd && no_cmd));

   a_r8_re_needs_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |-> (byte_stb && byte_rd && no_cmd));

   a_r10_access_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || ram_re) |-> (sub_cnt == SUB_W'(HW_SUB)));

   a_r11_row_mode_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      !mixed_mode |-> (!ram_we && !ram_re));

   a_r11_row_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!mixed_mode && no_cmd) |=> ($stable(ram_col) && $stable(ram_bank) && $stable(sub_cnt)));

   a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_stb && no_cmd) |=> ($stable(ram_col) && $stable(ram_bank) && $stable(sub_cnt)));

   a_r9_sub_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_dev_vld |=> (sub_cnt == $past(sub_cnt) || sub_cnt == SUB_W'($past(sub_cnt) + 1'b1)));

   a_r3_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ram_col <= COL_W'(NUM_COLS - 1));
endmodule

bind dram_addr_seq dram_addr_seq_chk #(
   .NUM_COLS (NUM_COLS),
   .NUM_BANKS(NUM_BANKS),
   .SUB_W    (SUB_W),
   .HW_SUB   (HW_SUB)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mixed_mode (mixed_mode),
   .cmd_dev_vld(cmd_dev_vld),
   .cmd_x_vld  (cmd_x_vld),
   .cmd_acc_vld(cmd_acc_vld),
   .byte_stb   (byte_stb),
   .byte_rd    (byte_rd),
   .ram_col    (ram_col),
   .ram_bank   (ram_bank),
   .ram_we     (ram_we),
   .ram_re     (ram_re),
   .sub_cnt    (sub_cnt)
);

// File: tb/tb_dram_addr_seq.sv
`timescale 1ns/1ps
module tb_dram_addr_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mixed_mode = 1'b0;
   logic       cmd_dev_vld = 1'b0;
   logic [3:0] cmd_dev_sub = '0;
   logic       cmd_x_vld = 1'b0;
   logic [5:0] cmd_x = '0;
   logic       cmd_acc_vld = 1'b0;
   logic [1:0] cmd_acc_mode = '0;
   logic [1:0] cmd_acc_bank = '0;
   logic       byte_stb = 1'b0;
   logic       byte_rd = 1'b0;
   logic [5:0] ram_col;
   logic [1:0] ram_bank;
   logic       ram_we, ram_re;
   logic [3:0] sub_cnt;

   always #4 clk = ~clk;

   dram_addr_seq dut (
      .clk(clk), .rst_n(rst_n), .mixed_mode(mixed_mode),
      .cmd_dev_vld(cmd_dev_vld), .cmd_dev_sub(cmd_dev_sub),
      .cmd_x_vld(cmd_x_vld), .cmd_x(cmd_x),
      .cmd_acc_vld(cmd_acc_vld), .cmd_acc_mode(cmd_acc_mode), .cmd_acc_bank(cmd_acc_bank),
      .byte_stb(byte_stb), .byte_rd(byte_rd),
      .ram_col(ram_col), .ram_bank(ram_bank), .ram_we(ram_we), .ram_re(ram_re),
      .sub_cnt(sub_cnt)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   string tag = "R1";

   // behavioural reference state
   int m_x = 0, m_xs = 0, m_b = 0, m_bs = 0, m_sub = 0, m_mode = 0, m_h = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_advance();
      int md;
      md = (m_mode == 3) ? 2 : m_mode;
      if (md == 2) begin
         if (m_x == 39) begin
            m_x = m_xs; m_b = (m_b + 1) % 4;
            if (m_b == m_bs) m_sub = (m_sub + 1) % 16;
         end else m_x++;
      end else if (md == 0) begin
         if (m_x % 8 != 7) m_x++;
         else if ((m_b + 1) % 4 != m_bs) begin
            m_x = m_x - 7; m_b = (m_b + 1) % 4;
         end else begin
            m_b = m_bs;
            if (m_x == 39) begin m_x = m_xs; m_sub = (m_sub + 1) % 16; end
            else m_x++;
         end
      end else begin
         if (m_h == 0) begin m_b = (m_b + 1) % 4; m_h = 1; end
         else begin
            m_h = 0;
            if (m_x == 39) begin
               m_x = m_xs; m_b = (m_b + 1) % 4;
               if (m_b == m_bs) m_sub = (m_sub + 1) % 16;
            end else begin m_x++; m_b = (m_b + 3) % 4; end
         end
      end
   endtask

   // One cycle: drive at the falling edge, compare before the rising edge, update the model after it.
   task automatic cyc(input bit dv, input int ds, input bit xv, input int xd,
                      input bit av, input int am, input int ab,
                      input bit mx, input bit stb, input bit rd);
      bit anyc, acc;
      string rq;
      cmd_dev_vld = dv; cmd_dev_sub = 4'(ds);
      cmd_x_vld = xv; cmd_x = 6'(xd);
      cmd_acc_vld = av; cmd_acc_mode = 2'(am); cmd_acc_bank = 2'(ab);
      mixed_mode = mx; byte_stb = stb; byte_rd = rd;
      #2;
      anyc = dv | xv | av;
      acc = stb && mx && !anyc && (m_sub == 0);
      chk(tag, "ram_col", int'(ram_col), m_x);
      chk(tag, "ram_bank", int'(ram_bank), m_b);
      chk(tag, "sub_cnt", int'(sub_cnt), m_sub);
      if (stb && anyc) rq = "R13";
      else if (stb && !mx) rq = "R11";
      else if (stb && m_sub != 0) rq = "R10";
      else rq = rd ? "R8" : "R7";
      chk(rq, "ram_we", int'(ram_we), int'(acc && !rd));
      chk(rq, "ram_re", int'(ram_re), int'(acc && rd));
      @(posedge clk);
      if (dv) m_sub = ds;
      if (xv && xd <= 39) begin m_x = xd; m_xs = xd; m_h = 0; end
      if (av) begin m_mode = am; m_b = ab; m_bs = ab; m_h = 0; end
      if (!anyc && mx && stb) model_advance();
      @(negedge clk);
   endtask

   task automatic setup(input int ds, input int xd, input int am, input int ab);
      cyc(1, ds, 0, 0, 0, 0, 0, 1, 0, 0);
      cyc(0, 0, 1, xd, 0, 0, 0, 1, 0, 0);
      cyc(0, 0, 0, 0, 1, am, ab, 1, 0, 0);
   endtask

   task automatic bytes(input int n, input bit rd);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, rd);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      tag = "R1";
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      // R2 loads, then R4 full-graphic from unaligned column with start bank 1
      tag = "R2"; setup(0, 30, 2, 1);
      tag = "R4"; bytes(44, 0);
      // R5 character order from column 32, bank 0
      tag = "R2"; setup(0, 32, 0, 0);
      tag = "R5"; bytes(36, 0);
      // R5 with unaligned start and non-zero bank
      tag = "R2"; setup(0, 21, 0, 3);
      tag = "R5"; bytes(40, 0);
      // R6 half-graphic from column 36, bank 2
      tag = "R2"; setup(0, 36, 1, 2);
      tag = "R6"; bytes(20, 0);
      // R8 reads advance like writes
      tag = "R2"; setup(0, 5, 2, 0);
      tag = "R8"; bytes(12, 1);
      // R9 subaddress 15 wraps to 0, then writes resume
      tag = "R2"; setup(15, 39, 2, 0);
      tag = "R9"; bytes(8, 0);
      // R3 out-of-range column load ignored
      tag = "R3";
      cyc(0, 0, 1, 45, 0, 0, 0, 1, 0, 0);
      cyc(0, 0, 1, 63, 0, 0, 0, 1, 0, 0);
      bytes(2, 0);
      // R11 row-only: strobes do nothing
      tag = "R11";
      for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, i % 2);
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      // R12 reserved code behaves like full-graphic
      tag = "R2"; setup(0, 37, 3, 2);
      tag = "R12"; bytes(14, 0);
      // R13 command with strobe drops the strobe
      tag = "R13";
      cyc(0, 0, 1, 10, 0, 0, 0, 1, 1, 0);
      cyc(0, 0, 0, 0, 1, 0, 1, 1, 1, 1);
      cyc(1, 0, 0, 0, 0, 0, 0, 1, 1, 0);
      bytes(3, 0);
      // R10 mismatch: pointer moves, no enables
      tag = "R2"; setup(4, 12, 2, 0);
      tag = "R10"; bytes(10, 0); bytes(3, 1);
      // mixed stimulus
      tag = "R4";
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom % 100;
         if (r < 2) cyc(1, $urandom % 3, 0, 0, 0, 0, 0, 1, 0, 0);
         else if (r < 4) cyc(0, 0, 1, $urandom % 48, 0, 0, 0, 1, $urandom % 2, 0);
         else if (r < 6) cyc(0, 0, 0, 0, 1, $urandom % 4, $urandom % 4, 1, 0, 0);
         else cyc(0, 0, 0, 0, 0, 0, 0, ($urandom % 10) != 0, ($urandom % 4) != 0, $urandom % 2);
      end
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule